// File: doc/BRIEF.md
# Masked Packed-AND Vector Unit

This unit computes a lane-wise bitwise AND across a vector datapath of up to 512 bits, cut into 64-bit lanes. It takes two source vectors and the destination's previous contents. It returns the next destination value and registers it for one clock. Each operand is handled as a raw bit pattern. The unit raises no flags and no exceptions.

Three operand-format classes select how the result is shaped:

- **Compact class:** the operation is fixed at 128 bits. The old destination takes the place of the first source, and everything above bit 127 passes through untouched.
- **Extended class:** works at 128, 256 or 512 bits. Every active lane is written, and the bits above the vector length are cleared.
- **Predicated class:** also clears the bits above the vector length. In addition it applies a per-lane write mask, which either merges with or zeroes the unselected lanes. It can also replicate the low 64 bits of a memory-sourced second operand into every active lane.

Top module: `simd_and_unit`

## Requirements
- R1: `vlen_sel` picks the active lane count: 2'd0 gives 2 lanes (128 bits), 2'd1 gives 4 lanes (256 bits), 2'd2 gives 8 lanes (512 bits). The unused code 2'd3 behaves as 2'd0.
- R2: In the predicated and extended classes, an active lane that is selected gets `src1 & src2` for that lane. A lane is selected when its `wmask` bit is set, or when `mask_en` is low.
- R3: In the predicated class, the broadcast form is used only when `bcast` and `src2_is_mem` are both high. In that form every active lane uses `src2[63:0]` as its second operand. If either signal is low, each lane uses its own slice of `src2`.
- R4: In the predicated class with `mask_en` high and `zero_mode` low, an active lane whose `wmask` bit is 0 keeps its `old_dst` value.
- R5: In the predicated class with `mask_en` high and `zero_mode` high, an active lane whose `wmask` bit is 0 becomes zero.
- R6: In the predicated and extended classes, every bit from the vector length up to bit 511 is zero.
- R7: In the compact class, `vlen_sel` and `src1` have no effect. Bits 127:0 become `old_dst & src2`, and bits 511:128 equal `old_dst[511:128]`.
- R8: The extended and compact classes ignore `wmask`, `mask_en`, `zero_mode`, `bcast` and `src2_is_mem`.
- R9: `enc_class` selects the class: 2'd0 is compact, 2'd1 is extended, 2'd2 is predicated. The unused code 2'd3 behaves as extended.
- R10: The result appears on `result` on the clock edge after the edge that samples `in_valid` high. `out_valid` is high for exactly that one cycle. Otherwise `result` holds its value.
- R11: A synchronous active-high `rst` clears `result` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| enc_class | input | 2 | Class: 0 compact, 1 extended, 2 predicated, 3 as extended |
| vlen_sel | input | 2 | Vector length: 0 128b, 1 256b, 2 512b, 3 as 128b |
| src1 | input | 512 | First source vector |
| src2 | input | 512 | Second source vector |
| old_dst | input | 512 | Previous destination contents |
| wmask | input | 8 | Per-lane write mask (bit j guards lane j) |
| mask_en | input | 1 | Enables write masking |
| zero_mode | input | 1 | 1: unselected lanes zero; 0: merge |
| bcast | input | 1 | Broadcast request |
| src2_is_mem | input | 1 | Second source came from memory |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 512 | Registered destination value |

## Verification
The bench goes after the following corner cases, each of which exposes a specific design mistake:

- **Merge and zero masking with a sparse mask.** A mixed-up merge/zero choice leaves stale or cleared lanes in the wrong places.
- **Broadcast with only one of its two enables set.** An unguarded broadcast replicates lane 0 when it should not.
- **Reserved length and class codes.** A decoder that falls through on these codes widens or mis-clears the result.
- **Compact-class operations with a nonzero `src1` and a 512-bit length code.** A design that reads `src1`, or that zeroes the upper bits, is exposed.
- **Extended-class operations with every masking and broadcast input asserted.** A design that leaks predication into that class is caught.
- **Idle cycles after each result.** A result register that moves without a strobe, or a strobe that stays high, shows up here.

// File: rtl/simd_and_pkg.sv
package simd_and_pkg;

  localparam int unsigned LANE_BITS = 64;
  localparam int unsigned LANE_MAX  = 8;

  typedef enum logic [1:0] {
    CLS_COMPACT    = 2'd0,
    CLS_EXTENDED   = 2'd1,
    CLS_PREDICATED = 2'd2,
    CLS_SPARE      = 2'd3
  } op_class_e;

  typedef enum logic [1:0] {
    LEN_128   = 2'd0,
    LEN_256   = 2'd1,
    LEN_512   = 2'd2,
    LEN_SPARE = 2'd3
  } vec_len_e;

  typedef enum logic [1:0] {
    LOP_AND  = 2'd0,
    LOP_KEEP = 2'd1,
    LOP_ZERO = 2'd2
  } lane_op_e;

  function automatic int unsigned len_lanes(input logic [1:0] code);
    case (code)
      LEN_256: len_lanes = 4;
      LEN_512: len_lanes = 8;
      default: len_lanes = 2;
    endcase
  endfunction

endpackage

// File: rtl/simd_lane_plan.sv
module simd_lane_plan
  import simd_and_pkg::*;
#(
  parameter int unsigned NUM_LANES    = LANE_MAX,
  parameter int unsigned COMPACT_LANE = 2
) (
  input  logic [1:0]                    enc_class,
  input  logic [1:0]                    vlen_sel,
  input  logic [NUM_LANES-1:0]          wmask,
  input  logic                          mask_en,
  input  logic                          zero_mode,
  input  logic                          bcast,
  input  logic                          src2_is_mem,
  output lane_op_e [NUM_LANES-1:0]      lane_op,
  output logic                          a_from_dst,
  output logic                          b_scalar
);

  logic        is_compact;
  logic        is_pred;
  int unsigned active_cnt;

  always_comb begin
    is_compact = (enc_class == CLS_COMPACT);
    is_pred    = (enc_class == CLS_PREDICATED);
    if (is_compact) active_cnt = COMPACT_LANE;
    else            active_cnt = len_lanes(vlen_sel);
    a_from_dst = is_compact;
    b_scalar   = is_pred && bcast && src2_is_mem;
  end

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    always_comb begin
      if (j >= active_cnt) begin
        lane_op[j] = is_compact ? LOP_KEEP : LOP_ZERO;
      end else if (is_pred && mask_en && !wmask[j]) begin
        lane_op[j] = zero_mode ? LOP_ZERO : LOP_KEEP;
      end else begin
        lane_op[j] = LOP_AND;
      end
    end
  end

endmodule

// File: rtl/simd_lane_slice.sv
module simd_lane_slice
  import simd_and_pkg::*;
#(
  parameter int unsigned LANE_W = LANE_BITS
) (
  input  logic [LANE_W-1:0] a_src,
  input  logic [LANE_W-1:0] a_dst,
  input  logic [LANE_W-1:0] b_lane,
  input  logic [LANE_W-1:0] b_bcast,
  input  logic              a_from_dst,
  input  logic              b_scalar,
  input  lane_op_e          op,
  output logic [LANE_W-1:0] y
);

  logic [LANE_W-1:0] opa;
  logic [LANE_W-1:0] opb;

  always_comb begin
    opa = a_from_dst ? a_dst : a_src;
    opb = b_scalar ? b_bcast : b_lane;
    case (op)
      LOP_AND:  y = opa & opb;
      LOP_KEEP: y = a_dst;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/simd_and_unit.sv
module simd_and_unit
  import simd_and_pkg::*;
#(
  parameter int unsigned LANE_W       = LANE_BITS,
  parameter int unsigned NUM_LANES    = LANE_MAX,
  parameter int unsigned COMPACT_LANE = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [1:0]                  enc_class,
  input  logic [1:0]                  vlen_sel,
  input  logic [LANE_W*NUM_LANES-1:0] src1,
  input  logic [LANE_W*NUM_LANES-1:0] src2,
  input  logic [LANE_W*NUM_LANES-1:0] old_dst,
  input  logic [NUM_LANES-1:0]        wmask,
  input  logic                        mask_en,
  input  logic                        zero_mode,
  input  logic                        bcast,
  input  logic                        src2_is_mem,
  output logic                        out_valid,
  output logic [LANE_W*NUM_LANES-1:0] result
);

  localparam int unsigned VEC_W = LANE_W * NUM_LANES;

  lane_op_e [NUM_LANES-1:0] lane_op;
  logic                     a_from_dst;
  logic                     b_scalar;
  logic [VEC_W-1:0]         next_val;

  simd_lane_plan #(
    .NUM_LANES   (NUM_LANES),
    .COMPACT_LANE(COMPACT_LANE)
  ) u_plan (
    .enc_class  (enc_class),
    .vlen_sel   (vlen_sel),
    .wmask      (wmask),
    .mask_en    (mask_en),
    .zero_mode  (zero_mode),
    .bcast      (bcast),
    .src2_is_mem(src2_is_mem),
    .lane_op    (lane_op),
    .a_from_dst (a_from_dst),
    .b_scalar   (b_scalar)
  );

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_slice
    simd_lane_slice #(.LANE_W(LANE_W)) u_slice (
      .a_src     (src1[j*LANE_W +: LANE_W]),
      .a_dst     (old_dst[j*LANE_W +: LANE_W]),
      .b_lane    (src2[j*LANE_W +: LANE_W]),
      .b_bcast   (src2[LANE_W-1:0]),
      .a_from_dst(a_from_dst),
      .b_scalar  (b_scalar),
      .op        (lane_op[j]),
      .y         (next_val[j*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_val;
    end
  end

endmodule

// File: rtl/simd_and_unit_chk.sv
module simd_and_unit_chk
  import simd_and_pkg::*;
#(
  parameter int unsigned LANE_W    = LANE_BITS,
  parameter int unsigned NUM_LANES = LANE_MAX
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic [1:0]                  enc_class,
  input logic [1:0]                  vlen_sel,
  input logic [LANE_W*NUM_LANES-1:0] src1,
  input logic [LANE_W*NUM_LANES-1:0] src2,
  input logic [LANE_W*NUM_LANES-1:0] old_dst,
  input logic [NUM_LANES-1:0]        wmask,
  input logic                        mask_en,
  input logic                        zero_mode,
  input logic                        bcast,
  input logic                        src2_is_mem,
  input logic                        out_valid,
  input logic [LANE_W*NUM_LANES-1:0] result
);

  localparam int unsigned VEC_W = LANE_W * NUM_LANES;
  localparam int unsigned TOP_L = (NUM_LANES - 1) * LANE_W;

  p_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  p_compact_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_class == CLS_COMPACT)
      |=> result[VEC_W-1:2*LANE_W] == $past(old_dst[VEC_W-1:2*LANE_W]));

  p_ext_upper_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_class == CLS_EXTENDED && vlen_sel == LEN_128)
      |=> result[VEC_W-1:2*LANE_W] == '0);

  p_and_lane0_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_class == CLS_PREDICATED && !mask_en && !(bcast && src2_is_mem))
      |=> result[LANE_W-1:0] == $past(src1[LANE_W-1:0] & src2[LANE_W-1:0]));

  p_merge_lane0_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_class == CLS_PREDICATED && mask_en && !zero_mode && !wmask[0])
      |=> result[LANE_W-1:0] == $past(old_dst[LANE_W-1:0]));

  p_zero_lane0_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_class == CLS_PREDICATED && mask_en && zero_mode && !wmask[0])
      |=> result[LANE_W-1:0] == '0);

  p_bcast_top_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_class == CLS_PREDICATED && vlen_sel == LEN_512 && !mask_en
     && bcast && src2_is_mem)
      |=> result[VEC_W-1:TOP_L] == $past(src1[VEC_W-1:TOP_L] & src2[LANE_W-1:0]));

endmodule

bind simd_and_unit simd_and_unit_chk #(
  .LANE_W   (LANE_W),
  .NUM_LANES(NUM_LANES)
) u_chk (.*);

// File: tb/simd_and_unit_bench.sv
module simd_and_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   enc_class;
  logic [1:0]   vlen_sel;
  logic [511:0] src1, src2, old_dst;
  logic [7:0]   wmask;
  logic         mask_en, zero_mode, bcast, src2_is_mem;
  logic         out_valid;
  logic [511:0] result;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_and_unit u_simd_and_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .enc_class(enc_class),
    .vlen_sel(vlen_sel), .src1(src1), .src2(src2), .old_dst(old_dst),
    .wmask(wmask), .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
    .src2_is_mem(src2_is_mem), .out_valid(out_valid), .result(result)
  );

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // Expected value built from R1..R9
  function automatic logic [511:0] expect_val(
    input logic [1:0] ec, input logic [1:0] vl,
    input logic [511:0] a, input logic [511:0] b, input logic [511:0] od,
    input logic [7:0] wm, input logic men, input logic zm,
    input logic bc, input logic mem);
    logic [511:0] r;
    logic [63:0]  opa, opb;
    int n;
    bit compact, pred;
    compact = (ec == 2'd0);
    pred    = (ec == 2'd2);
    if (compact)        n = 2;
    else if (vl == 2'd1) n = 4;
    else if (vl == 2'd2) n = 8;
    else                n = 2;
    for (int j = 0; j < 8; j++) begin
      opa = compact ? od[j*64 +: 64] : a[j*64 +: 64];
      opb = (pred && bc && mem) ? b[63:0] : b[j*64 +: 64];
      if (j >= n)                   r[j*64 +: 64] = compact ? od[j*64 +: 64] : 64'd0;
      else if (pred && men && !wm[j]) r[j*64 +: 64] = zm ? 64'd0 : od[j*64 +: 64];
      else                          r[j*64 +: 64] = opa & opb;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input string tag,
                       input logic [1:0] ec, input logic [1:0] vl,
                       input logic [511:0] a, input logic [511:0] b, input logic [511:0] od,
                       input logic [7:0] wm, input logic men, input logic zm,
                       input logic bc, input logic mem);
    logic [511:0] exp;
    logic [511:0] held;
    @(negedge clk);
    enc_class = ec; vlen_sel = vl; src1 = a; src2 = b; old_dst = od;
    wmask = wm; mask_en = men; zero_mode = zm; bcast = bc; src2_is_mem = mem;
    in_valid = 1'b1;
    exp = expect_val(ec, vl, a, b, od, wm, men, zm, bc, mem);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 strobe", {511'd0, out_valid}, 512'd1);
    chk(tag, result, exp);
    held = result;
    src1 = rnd512(); src2 = rnd512(); old_dst = rnd512();
    @(negedge clk);
    chk("R10 pulse", {511'd0, out_valid}, 512'd0);
    chk("R10 hold", result, held);
  endtask

  logic [511:0] A, B, D;

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; in_valid = 1'b0; enc_class = 2'd0; vlen_sel = 2'd0;
    src1 = '0; src2 = '0; old_dst = '0; wmask = '0;
    mask_en = 1'b0; zero_mode = 1'b0; bcast = 1'b0; src2_is_mem = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset valid", {511'd0, out_valid}, 512'd0);
    chk("R11 reset result", result, 512'd0);
    rst = 1'b0;

    A = rnd512(); B = rnd512(); D = rnd512();
    issue("R1 len256",        2'd1, 2'd1, A, B, D, 8'h00, 0, 0, 0, 0);
    issue("R1 len512",        2'd1, 2'd2, A, B, D, 8'h00, 0, 0, 0, 0);
    issue("R1 spare len",     2'd1, 2'd3, A, B, D, 8'h00, 0, 0, 0, 0);
    issue("R2 pred full",     2'd2, 2'd2, A, B, D, 8'h00, 0, 0, 0, 0);
    issue("R3 bcast mem",     2'd2, 2'd2, A, B, D, 8'hFF, 1, 0, 1, 1);
    issue("R3 bcast no mem",  2'd2, 2'd2, A, B, D, 8'hFF, 1, 0, 1, 0);
    issue("R3 mem no bcast",  2'd2, 2'd1, A, B, D, 8'hFF, 1, 0, 0, 1);
    issue("R4 merge",         2'd2, 2'd2, A, B, D, 8'hA5, 1, 0, 0, 0);
    issue("R5 zero",          2'd2, 2'd2, A, B, D, 8'hA5, 1, 1, 0, 0);
    issue("R6 pred upper",    2'd2, 2'd1, A, B, D, 8'h3C, 1, 1, 1, 1);
    issue("R6 ext upper",     2'd1, 2'd0, A, B, D, 8'h00, 0, 0, 0, 0);
    issue("R7 compact",       2'd0, 2'd2, A, B, D, 8'h00, 0, 0, 0, 0);
    issue("R8 ext ignores",   2'd1, 2'd2, A, B, D, 8'h00, 1, 1, 1, 1);
    issue("R8 cmp ignores",   2'd0, 2'd1, A, B, D, 8'h00, 1, 1, 1, 1);
    issue("R9 spare class",   2'd3, 2'd2, A, B, D, 8'h00, 1, 1, 1, 1);
    chk("R2 ones", expect_val(2'd2, 2'd2, {512{1'b1}}, B, D, 8'hFF, 0, 0, 0, 0), B);

    for (int t = 0; t < 400; t++) begin
      logic [1:0] ec, vl;
      string tg;
      ec = 2'($urandom % 4);
      vl = 2'($urandom % 4);
      if (ec == 2'd0)      tg = "R7 rand";
      else if (ec == 2'd2) tg = "R2 rand";
      else                 tg = "R6 rand";
      issue(tg, ec, vl, rnd512(), rnd512(), rnd512(), 8'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule